// File: doc/BRIEF.md
# Row-Pipelined 4x4 Sum-of-Absolute-Differences Group

This block measures how well a fixed 4x4 block of current pixels matches a column of candidate positions in a reference window. First the sixteen current pixels are written one per cycle. After that they stay fixed while the search runs. Next, one reference row of four pixels is broadcast to all four rows of the group in each cycle. Row r compares its current row against the reference row it receives. Because of this, at any moment each row works on a different vertical candidate: row r is r positions behind row 0.

Each row turns its four absolute differences into a carry vector and a sum vector with a tree of 4:2 compressors. The row's input partial sum also enters that tree as a carry/sum pair. The pair then moves down to the next row through delay registers, and no adder resolves it on the way. Every absolute-difference element yields a magnitude and a one-bit correction, and those correction bits go into the compressor tree in spare carry slots. Only one carry-propagate adder sits below the last row. Its result is registered, which gives one 12-bit SAD per accepted reference row once the pipeline is full.

Top module: `sad_pp4_group`

## Requirements
- R1: While `rst_ni` is low, `sad_vld_o` is 0 and `sad_o` is 0.
- R2: When `cur_we_i` is high at a clock edge, `cur_pix_i` is stored as the current pixel at row `cur_idx_i[3:2]`, column `cur_idx_i[1:0]` (index = row*4 + column).
- R3: Reference lane x (column x, x = 0..3) of a broadcast row is carried on `ref_row_i[8*x+7 : 8*x]`.
- R4: Let rows k, k+1, k+2 and k+3 of a strip be accepted at four consecutive edges. Then at the edge that accepts row k+3, `sad_o` takes the value sum over r, x of |C[r][x] - Ref[k+r][x]|.
- R5: After an edge, `sad_vld_o` is 1 exactly when `ref_vld_i` was high at that edge and at the three edges before it. Otherwise it is 0.
- R6: A cycle with `ref_vld_i` low starts a new strip. No valid result follows until four further rows have been accepted in a row, and those results use only the rows of the new strip.
- R7: With every pixel pair at full-scale difference (0 against 255), `sad_o` is 4080 and does not wrap. With identical pixels it is 0.
- R8: While `cur_we_i` is low, `cur_idx_i` and `cur_pix_i` have no effect: the stored current block, and therefore every SAD, is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_we_i | input | 1 | Current-pixel write strobe |
| cur_idx_i | input | 4 | Current-pixel index, row*4+column |
| cur_pix_i | input | 8 | Current-pixel value |
| ref_vld_i | input | 1 | A reference row is present this cycle |
| ref_row_i | input | 32 | Four reference pixels, lane x at bits 8x+7:8x |
| sad_vld_o | output | 1 | `sad_o` holds a complete 4x4 SAD |
| sad_o | output | 12 | SAD of the candidate whose last row was just accepted |

## Verification
The SAD for candidate k is due at the same edge that accepts the strip's fourth row, k+3. Its valid flag is due at that same edge. The bench changes inputs on falling edges. For every reference cycle it drives, it pushes into a queue one expected item: the valid bit, and the sum computed from its own four-row window. The monitor removes one item per rising edge, one nanosecond after the edge, and compares it, so a result that is early or late by one cycle fails. Strips broken by gaps test the refill, and full-scale and identical blocks test the SAD's range.

// File: rtl/sadg_pkg.sv
package sadg_pkg;
  localparam int BLK = 4;  // group is BLK x BLK pixels, one PE row per pixel row

  function automatic int sad_bits(int pix_w);
    return pix_w + 2 * $clog2(BLK);
  endfunction
endpackage

// File: rtl/sad_ad_pe.sv
// |R-C| split as magnitude plus correction bit; current pixel arrives inverted.
module sad_ad_pe #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] ref_i,
  input  logic [PIX_W-1:0] cur_inv_i,
  output logic [PIX_W-1:0] mag_o,
  output logic             cor_o
);
  logic [PIX_W:0] sum;

  assign sum   = {1'b0, ref_i} + {1'b0, cur_inv_i};
  assign cor_o = sum[PIX_W];
  assign mag_o = sum[PIX_W-1:0] ^ {PIX_W{~sum[PIX_W]}};
endmodule

// File: rtl/sad_csa42.sv
// Vector 4:2 compressor: two chained full adders per bit, horizontal carry chain.
// sum_o + carry_o == a+b+c+d+cin_i+cl_i (mod 2^W)
module sad_csa42 #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  input  logic         cin_i,
  input  logic         cl_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] s1;
  logic [W-1:0] hin;
  logic [W-2:0] h;
  logic [W-2:0] k;

  for (genvar j = 0; j < W; j++) begin : g_bit
    assign s1[j]    = a_i[j] ^ b_i[j] ^ c_i[j];
    assign sum_o[j] = s1[j] ^ d_i[j] ^ hin[j];
    if (j == 0) begin : g_lsb
      assign hin[j] = cin_i;
    end else begin : g_up
      assign hin[j] = h[j-1];
    end
    if (j < W - 1) begin : g_co
      assign h[j] = (a_i[j] & b_i[j]) | (a_i[j] & c_i[j]) | (b_i[j] & c_i[j]);
      assign k[j] = (s1[j] & d_i[j]) | (s1[j] & hin[j]) | (d_i[j] & hin[j]);
    end
  end

  assign carry_o = {k, cl_i};
endmodule

// File: rtl/sad_row_acc.sv
// One PE row: four differences plus the incoming carry/sum pair, left unresolved.
module sad_row_acc #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 12
) (
  input  logic [sadg_pkg::BLK*PIX_W-1:0] ref_row_i,
  input  logic [sadg_pkg::BLK*PIX_W-1:0] cur_inv_i,
  input  logic [SAD_W-1:0]               s_i,
  input  logic [SAD_W-1:0]               c_i,
  output logic [SAD_W-1:0]               s_o,
  output logic [SAD_W-1:0]               c_o
);
  localparam int BLK = sadg_pkg::BLK;
  localparam int EXT = SAD_W - PIX_W;

  logic [PIX_W-1:0] mag [BLK];
  logic [SAD_W-1:0] mag_x [BLK];
  logic [BLK-1:0]   cor;
  logic [SAD_W-1:0] s_a, c_a;

  for (genvar x = 0; x < BLK; x++) begin : g_pe
    sad_ad_pe #(.PIX_W(PIX_W)) u_pe (
      .ref_i     (ref_row_i[x*PIX_W +: PIX_W]),
      .cur_inv_i (cur_inv_i[x*PIX_W +: PIX_W]),
      .mag_o     (mag[x]),
      .cor_o     (cor[x])
    );
    assign mag_x[x] = {{EXT{1'b0}}, mag[x]};
  end

  // level 1: four magnitudes, two correction bits
  sad_csa42 #(.W(SAD_W)) u_lvl1 (
    .a_i(mag_x[0]), .b_i(mag_x[1]), .c_i(mag_x[2]), .d_i(mag_x[3]),
    .cin_i(cor[0]), .cl_i(cor[1]), .sum_o(s_a), .carry_o(c_a)
  );

  // level 2: merge with pair from the row above, remaining correction bits
  sad_csa42 #(.W(SAD_W)) u_lvl2 (
    .a_i(s_a), .b_i(c_a), .c_i(s_i), .d_i(c_i),
    .cin_i(cor[2]), .cl_i(cor[3]), .sum_o(s_o), .carry_o(c_o)
  );
endmodule

// File: rtl/sad_pp4_group.sv
module sad_pp4_group #(
  parameter int PIX_W = 8
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       cur_we_i,
  input  logic [$clog2(sadg_pkg::BLK*sadg_pkg::BLK)-1:0] cur_idx_i,
  input  logic [PIX_W-1:0]                           cur_pix_i,
  input  logic                                       ref_vld_i,
  input  logic [sadg_pkg::BLK*PIX_W-1:0]             ref_row_i,
  output logic                                       sad_vld_o,
  output logic [sadg_pkg::sad_bits(PIX_W)-1:0]       sad_o
);
  localparam int BLK   = sadg_pkg::BLK;
  localparam int SAD_W = sadg_pkg::sad_bits(PIX_W);
  localparam int ROW_W = BLK * PIX_W;
  localparam int CNT_W = $clog2(BLK);
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(BLK - 1);

  // current block, stored inverted
  logic [BLK*ROW_W-1:0] cur_inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_inv_q <= '1;
    else if (cur_we_i) cur_inv_q[cur_idx_i*PIX_W +: PIX_W] <= ~cur_pix_i;
  end

  logic [SAD_W-1:0] s_in  [BLK];
  logic [SAD_W-1:0] c_in  [BLK];
  logic [SAD_W-1:0] s_row [BLK];
  logic [SAD_W-1:0] c_row [BLK];
  logic [SAD_W-1:0] s_q   [BLK-1];
  logic [SAD_W-1:0] c_q   [BLK-1];

  for (genvar r = 0; r < BLK; r++) begin : g_row
    if (r == 0) begin : g_top
      assign s_in[r] = '0;
      assign c_in[r] = '0;
    end else begin : g_chain
      assign s_in[r] = s_q[r-1];
      assign c_in[r] = c_q[r-1];
    end

    sad_row_acc #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_row (
      .ref_row_i (ref_row_i),
      .cur_inv_i (cur_inv_q[r*ROW_W +: ROW_W]),
      .s_i       (s_in[r]),
      .c_i       (c_in[r]),
      .s_o       (s_row[r]),
      .c_o       (c_row[r])
    );

    if (r < BLK - 1) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s_q[r] <= '0;
          c_q[r] <= '0;
        end else begin
          s_q[r] <= s_row[r];
          c_q[r] <= c_row[r];
        end
      end
    end
  end

  // fill tracking: consecutive accepted rows, saturating
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      sad_vld_o <= 1'b0;
      sad_o     <= '0;
    end else begin
      if (!ref_vld_i) run_q <= '0;
      else if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
      sad_vld_o <= ref_vld_i && (run_q == RUN_FULL);
      sad_o     <= s_row[BLK-1] + c_row[BLK-1];  // single carry-propagate adder
    end
  end
endmodule

// File: rtl/sad_pp4_group_chk.sv
module sad_pp4_group_chk #(
  parameter int PIX_W = 8
) (
  input logic                                            clk_i,
  input logic                                            rst_ni,
  input logic                                            cur_we_i,
  input logic                                            ref_vld_i,
  input logic                                            sad_vld_o,
  input logic [sadg_pkg::sad_bits(PIX_W)-1:0]            sad_o,
  input logic [sadg_pkg::BLK*sadg_pkg::BLK*PIX_W-1:0]    cur_inv_q
);
  localparam int BLK   = sadg_pkg::BLK;
  localparam int SAD_W = sadg_pkg::sad_bits(PIX_W);
  localparam logic [SAD_W-1:0] SAD_MAX = SAD_W'(BLK * BLK * ((1 << PIX_W) - 1));

  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 3'd4) age_q <= age_q + 3'd1;
  end

  AST_VLD_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sad_vld_o |-> ($past(ref_vld_i) && $past(ref_vld_i, 2) && $past(ref_vld_i, 3) && $past(ref_vld_i, 4))); // R5

  AST_RUN_GIVES_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 3'd4) && $past(ref_vld_i) && $past(ref_vld_i, 2) && $past(ref_vld_i, 3) && $past(ref_vld_i, 4)) |-> sad_vld_o); // R5

  AST_GAP_DROPS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_vld_i) |-> !sad_vld_o); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sad_vld_o |-> (sad_o <= SAD_MAX)); // R7

  AST_CUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_we_i |=> $stable(cur_inv_q)); // R8
endmodule

bind sad_pp4_group sad_pp4_group_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/sim_sad_pp4_group.sv
module sim_sad_pp4_group;
  localparam int PIX_W = 8;
  localparam int SAD_W = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cur_we_i = 1'b0;
  logic [3:0]  cur_idx_i = '0;
  logic [7:0]  cur_pix_i = '0;
  logic        ref_vld_i = 1'b0;
  logic [31:0] ref_row_i = '0;
  logic        sad_vld_o;
  logic [SAD_W-1:0] sad_o;

  always #2 clk = ~clk;  // 250 MHz

  sad_pp4_group #(.PIX_W(PIX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cur_we_i(cur_we_i), .cur_idx_i(cur_idx_i),
    .cur_pix_i(cur_pix_i), .ref_vld_i(ref_vld_i), .ref_row_i(ref_row_i),
    .sad_vld_o(sad_vld_o), .sad_o(sad_o)
  );

  typedef struct { bit vld; int sad; string tag; } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_bad = 0;
  int cur_m [16];
  int win [4][4];
  int run = 0;
  bit done = 1'b0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_cur(input int pix [16]);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ref_vld_i = 1'b0;
      cur_we_i  = 1'b1;
      cur_idx_i = 4'(i);
      cur_pix_i = 8'(pix[i]);
      cur_m[i]  = pix[i];
    end
    @(negedge clk);
    cur_we_i = 1'b0;
    run = 0;
  endtask

  // driver: one reference cycle, expectation pushed for the same edge
  task automatic drive(bit v, logic [31:0] row, string tag);
    exp_t e;
    int s;
    @(negedge clk);
    ref_vld_i = v;
    ref_row_i = row;
    cur_we_i  = 1'b0;
    cur_idx_i = 4'($urandom);
    cur_pix_i = 8'($urandom);  // R8: ignored while write strobe low
    if (v) begin
      for (int i = 0; i < 3; i++) win[i] = win[i+1];
      for (int x = 0; x < 4; x++) win[3][x] = int'(row[8*x +: 8]);
      run++;
    end else begin
      run = 0;
    end
    s = 0;
    for (int r = 0; r < 4; r++)
      for (int x = 0; x < 4; x++) begin
        int d;
        d = cur_m[r*4+x] - win[r][x];
        s += (d < 0) ? -d : d;
      end
    e.vld = (run >= 4);
    e.sad = s;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check("R5 valid", int'(sad_vld_o), int'(e.vld));
        if (e.vld) check({e.tag, " sad"}, int'(sad_o), e.sad);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pix [16];
    #9;
    check("R1 reset vld", int'(sad_vld_o), 0);
    check("R1 reset sad", int'(sad_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 / R4: random block, long strip
    for (int i = 0; i < 16; i++) pix[i] = int'($urandom_range(0, 255));
    load_cur(pix);
    for (int n = 0; n < 20; n++) drive(1'b1, $urandom, "R2");
    drive(1'b0, '0, "R4");
    for (int n = 0; n < 12; n++) drive(1'b1, $urandom, "R4");

    // R3: one lane active at a time
    for (int x = 0; x < 4; x++) begin
      drive(1'b0, '0, "R3");
      for (int n = 0; n < 6; n++) drive(1'b1, 32'($urandom_range(1, 255)) << (8*x), "R3");
    end

    // R6: gaps break strips
    drive(1'b0, '0, "R6");
    for (int n = 0; n < 6; n++) drive(1'b1, $urandom, "R6");
    drive(1'b0, '0, "R6");
    for (int n = 0; n < 3; n++) drive(1'b1, $urandom, "R6");
    drive(1'b0, '0, "R6");
    drive(1'b0, '0, "R6");
    for (int n = 0; n < 5; n++) drive(1'b1, $urandom, "R6");

    // R8: new block, random data on idle write port throughout
    for (int i = 0; i < 16; i++) pix[i] = int'($urandom_range(0, 255));
    load_cur(pix);
    for (int n = 0; n < 10; n++) drive(1'b1, $urandom, "R8");

    // R7: full scale and identical
    for (int i = 0; i < 16; i++) pix[i] = 0;
    load_cur(pix);
    for (int n = 0; n < 5; n++) drive(1'b1, 32'hFFFF_FFFF, "R7");
    for (int i = 0; i < 16; i++) pix[i] = 255;
    load_cur(pix);
    for (int n = 0; n < 5; n++) drive(1'b1, 32'hFFFF_FFFF, "R7");
    drive(1'b0, '0, "R7");
    for (int n = 0; n < 5; n++) drive(1'b1, 32'h0, "R7");
    drive(1'b0, '0, "R7");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule